// File: doc/BRIEF.md
# Configurable Two-Level Lookup Logic Cell

The block models one programmable logic cell. Two four-input lookup tables (called F and G here) each realise any Boolean function of their own four pins. A second-level three-input table (H) combines them: its outer two inputs can each take a first-level table result or an external pin. Its middle input is always an external pin. The cell can therefore produce any four-input function together with a second one, any five-input function, or certain functions of up to nine inputs such as a nine-bit parity. Because every table is a plain memory read addressed by its inputs, the delay does not depend on the programmed function.

Two combinational outputs choose between a first-level result and the H result. Two rising-edge flip-flops capture a table result or the direct data input. Each flip-flop has a clock enable and a synchronous clear. When three distinct functions are needed, only two can leave unregistered, so the third passes through a flip-flop.

The 48-bit configuration word is shifted in serially, MSB first, before use. While shifting is active, every output is forced low.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en_i` is high, each rising clock edge shifts `cfg_din_i` into bit 0 of the 48-bit configuration word and moves the older bits up by one, so the first bit sent ends in bit 47. While `cfg_en_i` is low, the word holds its value. The word layout is:
  - F table in [47:32] and G table in [31:16], entry n held in bit n of each field.
  - H table in [15:8].
  - H top-input select in [7] and H bottom-input select in [6].
  - X select in [5] and Y select in [4].
  - Flip-flop A source in [3:2] and flip-flop B source in [1:0].
- R2: While `cfg_en_i` is high, `x_o`, `y_o`, `qa_o` and `qb_o` are all 0, and neither flip-flop updates.
- R3: The F result is the F-table bit indexed by `f_i`, read as an unsigned number with `f_i[0]` as the LSB. The G result is formed the same way from `g_i`. Both are combinational.
- R4: The H result is the H-table bit indexed by {top, `h_i[1]`, bottom}:
  - The top bit is the F result when bit 7 is 1, and `h_i[2]` otherwise.
  - The bottom bit is the G result when bit 6 is 1, and `h_i[0]` otherwise.
- R5: `x_o` carries the H result when bit 5 is 1 and the F result otherwise. `y_o` carries the H result when bit 4 is 1 and the G result otherwise.
- R6: A flip-flop whose enable `ce_i` is high captures its selected source on the rising edge. The source codes are 0 for F, 1 for G, 2 for H and 3 for `din_i`. Flip-flop A drives `qa_o` and flip-flop B drives `qb_o`.
- R7: A high `sr_i` clears both flip-flops to 0 at the next rising edge, even when `ce_i` is high.
- R8: With `ce_i` low and `sr_i` low, both flip-flops hold their value whatever `din_i` does.
- R9: A low `rst_ni` at once clears the configuration word and both flip-flops, so all outputs read 0.
- R10: With both H input selects set, the cell computes a nine-input function of `f_i`, `g_i` and `h_i[1]`, such as a nine-bit parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_din_i | input | 1 | Configuration serial data, MSB first |
| f_i | input | 4 | F table inputs |
| g_i | input | 4 | G table inputs |
| h_i | input | 3 | External H inputs: [2] top, [1] middle, [0] bottom |
| din_i | input | 1 | Direct flip-flop data input |
| ce_i | input | 1 | Flip-flop clock enable |
| sr_i | input | 1 | Flip-flop synchronous clear |
| x_o | output | 1 | Combinational output, F or H |
| y_o | output | 1 | Combinational output, G or H |
| qa_o | output | 1 | Flip-flop A output |
| qb_o | output | 1 | Flip-flop B output |

## Verification
The hardest situation to reach is the nine-input path. In that path an H-table entry is addressed by two table results that are themselves addressed by eight pins, so a wrong select bit or a misplaced field appears only for some input patterns. The stimulus therefore walks several complete configuration words. It shifts each one in serially and then sweeps all 2048 combinations of the eleven table pins, comparing every output with a model written from the bit layout. Directed steps then cover clear priority over enable, hold with enable low, and an asynchronous reset arriving in the middle of a cycle.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int unsigned FG_IN    = 4;
  localparam int unsigned H_IN     = 3;
  localparam int unsigned FG_DEPTH = 1 << FG_IN;
  localparam int unsigned H_DEPTH  = 1 << H_IN;
  localparam int unsigned N_FF     = 2;

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } ff_src_e;

  typedef struct packed {
    logic [FG_DEPTH-1:0]     f_tbl;
    logic [FG_DEPTH-1:0]     g_tbl;
    logic [H_DEPTH-1:0]      h_tbl;
    logic                    h2_from_f;
    logic                    h0_from_g;
    logic                    x_from_h;
    logic                    y_from_h;
    logic [N_FF-1:0][1:0]    ff_src;  // [1] = A, [0] = B
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned DEPTH = 1 << N_IN
) (
  input  logic [DEPTH-1:0] tbl_i,
  input  logic [N_IN-1:0]  idx_i,
  output logic             out_o
);
  assign out_o = tbl_i[idx_i];
endmodule

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         shift_din_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_o <= '0;
    else if (shift_en_i) cfg_o <= {cfg_o[W-2:0], shift_din_i};
  end
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (en_i)  q_o <= d_i;
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_din_i,
  input  logic [FG_IN-1:0] f_i,
  input  logic [FG_IN-1:0] g_i,
  input  logic [H_IN-1:0]  h_i,
  input  logic             din_i,
  input  logic             ce_i,
  input  logic             sr_i,
  output logic             x_o,
  output logic             y_o,
  output logic             qa_o,
  output logic             qb_o
);
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic             f_out, g_out, h_out;
  logic [H_IN-1:0]  h_idx;
  logic [N_FF-1:0]  ff_d, ff_q;
  logic             quiet;

  assign cfg   = cfg_t'(cfg_q);
  assign quiet = cfg_en_i;

  lut_cell_cfg #(.W(CFG_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (cfg_en_i),
    .shift_din_i (cfg_din_i),
    .cfg_o       (cfg_q)
  );

  lut_cell_lut #(.N_IN(FG_IN)) u_f (.tbl_i(cfg.f_tbl), .idx_i(f_i), .out_o(f_out));
  lut_cell_lut #(.N_IN(FG_IN)) u_g (.tbl_i(cfg.g_tbl), .idx_i(g_i), .out_o(g_out));

  // top and bottom H inputs may be fed back from the first level
  assign h_idx = {cfg.h2_from_f ? f_out : h_i[2],
                  h_i[1],
                  cfg.h0_from_g ? g_out : h_i[0]};

  lut_cell_lut #(.N_IN(H_IN)) u_h (.tbl_i(cfg.h_tbl), .idx_i(h_idx), .out_o(h_out));

  for (genvar k = 0; k < N_FF; k++) begin : g_ff
    always_comb begin
      case (ff_src_e'(cfg.ff_src[k]))
        SRC_F:   ff_d[k] = f_out;
        SRC_G:   ff_d[k] = g_out;
        SRC_H:   ff_d[k] = h_out;
        default: ff_d[k] = din_i;
      endcase
    end

    lut_cell_ff u_ff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ce_i & ~quiet),
      .clr_i  (sr_i),
      .d_i    (ff_d[k]),
      .q_o    (ff_q[k])
    );
  end

  assign x_o  = ~quiet & (cfg.x_from_h ? h_out : f_out);
  assign y_o  = ~quiet & (cfg.y_from_h ? h_out : g_out);
  assign qa_o = ~quiet & ff_q[1];
  assign qb_o = ~quiet & ff_q[0];
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_din_i,
  input logic [FG_IN-1:0] f_i,
  input logic             din_i,
  input logic             ce_i,
  input logic             sr_i,
  input logic             x_o,
  input logic             y_o,
  input logic             qa_o,
  input logic             qb_o,
  input logic [CFG_W-1:0] cfg_q,
  input logic [N_FF-1:0]  ff_q
);
  cfg_t cfg;
  assign cfg = cfg_t'(cfg_q);

  // R1
  cfg_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q[0] == $past(cfg_din_i));

  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));

  // R2
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> !(x_o || y_o || qa_o || qb_o));

  // R3
  f_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && !cfg.x_from_h) |-> x_o == cfg.f_tbl[f_i]);

  // R6
  din_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !sr_i && !cfg_en_i && cfg.ff_src[1] == SRC_DIN) |=> ff_q[1] == $past(din_i));

  // R7
  sr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_i |=> ff_q == '0);

  // R8
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_i && (!ce_i || cfg_en_i)) |=> $stable(ff_q));
endmodule

bind lut_cell lut_cell_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .cfg_din_i (cfg_din_i),
  .f_i       (f_i),
  .din_i     (din_i),
  .ce_i      (ce_i),
  .sr_i      (sr_i),
  .x_o       (x_o),
  .y_o       (y_o),
  .qa_o      (qa_o),
  .qb_o      (qb_o),
  .cfg_q     (cfg_q),
  .ff_q      (ff_q)
);

// File: tb/lut_cell_tb_top.sv
module lut_cell_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_din = 1'b0;
  logic [3:0] f = '0, g = '0;
  logic [2:0] h = '0;
  logic       din = 1'b0, ce = 1'b0, sr = 1'b0;
  logic       x, y, qa, qb;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  lut_cell dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_din_i(cfg_din),
    .f_i(f), .g_i(g), .h_i(h), .din_i(din), .ce_i(ce), .sr_i(sr),
    .x_o(x), .y_o(y), .qa_o(qa), .qb_o(qb)
  );

  // config words: {F, G, H, h2_from_f, h0_from_g, x_from_h, y_from_h, srcA, srcB}
  localparam logic [47:0] CFG_TBL [4] = '{
    {16'h6996, 16'h6996, 8'h96, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0},  // 9-bit parity on X
    {16'h8000, 16'hFFFE, 8'hE2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd2},  // h1 selects AND4 / OR4
    {16'hA5C3, 16'h1234, 8'hE8, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 2'd2},  // H from pins, majority
    {16'hCAFE, 16'h3C5A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3}   // plain F / G, DIN to B
  };

  function automatic logic [3:0] ref_eval(input logic [47:0] w, input logic [3:0] fi, gi,
                                          input logic [2:0] hi, input logic di);
    logic fo, go, ho, da, db;
    logic [2:0] hx;
    fo = w[32 + int'(fi)];
    go = w[16 + int'(gi)];
    hx = {w[7] ? fo : hi[2], hi[1], w[6] ? go : hi[0]};
    ho = w[8 + int'(hx)];
    case (w[3:2]) 2'd0: da = fo; 2'd1: da = go; 2'd2: da = ho; default: da = di; endcase
    case (w[1:0]) 2'd0: db = fo; 2'd1: db = go; 2'd2: db = ho; default: db = di; endcase
    return {w[5] ? ho : fo, w[4] ? ho : go, da, db};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load(input logic [47:0] w);
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = w[i];
      #1 chk("R2 load quiet", {x, y, qa, qb}, 4'h0);
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] e;
    string tg [4];
    tg[0] = "R10 R1"; tg[1] = "R5"; tg[2] = "R4"; tg[3] = "R3";
    repeat (3) @(negedge clk);
    f = 4'h1;
    #1 chk("R9 reset state", {x, y, qa, qb}, 4'h0);
    rst_n = 1'b1;

    for (int c = 0; c < 4; c++) begin
      f = 4'h1; g = 4'h3; h = 3'h7; ce = 1'b1; sr = 1'b0;
      load(CFG_TBL[c]);
      for (int v = 0; v < 2048; v++) begin
        if (v != 0) @(negedge clk);
        f = v[3:0]; g = v[7:4]; h = v[10:8]; din = v[0] ^ v[5];
        e = ref_eval(CFG_TBL[c], f, g, h, din);
        #1 chk(tg[c], {2'b00, x, y}, {2'b00, e[3:2]});
        @(posedge clk);
        #1 chk("R6 capture", {2'b00, qa, qb}, {2'b00, e[1:0]});
      end
    end

    // config 3 loaded: B takes din_i, F = 16'hCAFE
    @(negedge clk); ce = 1'b1; sr = 1'b0; din = 1'b1;
    @(posedge clk); #1 chk("R6 din to B", {3'b000, qb}, 4'h1);
    @(negedge clk); ce = 1'b0; din = 1'b0;
    @(posedge clk); #1 chk("R8 hold", {3'b000, qb}, 4'h1);
    @(negedge clk); din = 1'b1;
    @(posedge clk); #1 chk("R8 hold toggle", {3'b000, qb}, 4'h1);
    @(negedge clk); ce = 1'b1; sr = 1'b1; din = 1'b1; g = 4'h1;
    @(posedge clk); #1 chk("R7 clear beats enable", {2'b00, qa, qb}, 4'h0);
    @(negedge clk); sr = 1'b0;
    @(posedge clk); #1 chk("R6 recapture", {2'b00, qa, qb}, 4'h3);
    @(negedge clk); f = 4'h1;
    #1 chk("R3 F read", {3'b000, x}, 4'h1);
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", {x, y, qa, qb}, 4'h0);
    @(negedge clk); rst_n = 1'b1; ce = 1'b0;
    #1 chk("R9 config cleared", {x, y, qa, qb}, 4'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule